// File: doc/BRIEF.md
# GPIO Port Interrupt Router

This block is a slice of a general-purpose I/O controller that serves a small set of ports, each holding several pins. Software sets each pin's drive direction and output value, and reads the pin's input level, through a word-addressed register bus. The bus has single-cycle write and read strobes. Read data is registered and appears on the cycle after the read strobe.

Each pin has a trigger code that selects rising edge, falling edge, either edge, high level or low level. Each pin also has an interrupt enable and a route field. The route field sends the pin to exactly one of several interrupt outputs, so that different processors can each service their own subset of pins. Every output has its own status register covering all pins of the port set. Each interrupt output is the registered OR of the enabled status bits routed to it.

Edge status bits are sticky and are cleared by writing one to them. Level status bits track the synchronised input level. Pin inputs pass through a two-flop synchroniser before any detection or readback.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, every configuration and status register reads zero, `pin_oe`, `pin_out` and `irq` are zero, and `pin_oe`/`pin_out` always mirror the direction (1 = drive) and output-value registers.
- R2: The input register of a port returns the pin levels after a two-flop synchroniser, whatever the pin direction.
- R3: Trigger code 1 sets the pin's status bit on a 0-to-1 change of the synchronised input only.
- R4: Trigger code 2 sets the pin's status bit on a 1-to-0 change only.
- R5: Trigger code 3 sets the status bit on either change.
- R6: Trigger code 4 makes the status bit equal the synchronised level, and a write-one-to-clear has no effect on it while the level is high.
- R7: Trigger code 8 makes the status bit equal the inverted synchronised level.
- R8: Trigger codes 0, 5, 6, 7 and 9 to 15 keep the pin's status bit at zero for all input activity.
- R9: An edge status bit stays set until software writes 1 to its bit in the status register of the output the pin is routed to. Writing 0 leaves it set.
- R10: A pin's route field (0..3) selects one interrupt output. Status register o shows only the pins routed to o, and `irq[o]` is the OR of those bits that are enabled.
- R11: Clearing a pin's enable removes it from `irq` but does not stop its status bit from being captured or shown.
- R12: Port p's registers sit at word address 8p + offset, with these offsets: 0 direction, 1 output value, 2 input (read-only), 3 enable, 4 trigger (4 bits per pin, pin i at bits 4i+3:4i), 5 route (2 bits per pin, pin i at bits 2i+1:2i). Status register for output o is at address 16 + o, and pin i of port p is at bit 8p + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| pin_in | input | 16 | Pin input levels, asynchronous |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |
| irq | output | 4 | Interrupt outputs |

## Verification
The main sweep visits every pin with all sixteen trigger codes. For each pin and code it applies a low settle, a rise, a clear and a fall. This separates the five valid codes from one another and from every invalid code, and it shows sticky behaviour against level tracking. Each step rotates the route, so every output is used by every code. A second sweep drives several multi-pin level patterns with a fixed interleaved routing, which shows whether the status bits and `irq` follow the route mask. Running that sweep again with one port's enables cleared separates masking from capture. Write-zero and write-one to the status registers show the difference between sticky edge bits and held level bits.

// File: rtl/gpir_pkg.sv
package gpir_pkg;
  localparam int REG_STRIDE = 8;
  localparam int OFF_DIR    = 0;
  localparam int OFF_OUT    = 1;
  localparam int OFF_IN     = 2;
  localparam int OFF_IEN    = 3;
  localparam int OFF_TRIG   = 4;
  localparam int OFF_ROUTE  = 5;
  localparam int TRIG_W     = 4;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_RISE = 4'd1,
    TRIG_FALL = 4'd2,
    TRIG_BOTH = 4'd3,
    TRIG_HIGH = 4'd4,
    TRIG_LOW  = 4'd8
  } trig_e;
endpackage

// File: rtl/gpir_sync.sv
module gpir_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpir_detect.sv
module gpir_detect
  import gpir_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NPIN-1:0]             lvl,
  input  logic [NPIN-1:0][TRIG_W-1:0] trig,
  input  logic [NPIN-1:0]             clr,
  output logic [NPIN-1:0]             st
);
  logic [NPIN-1:0] prev_q, st_q, st_d;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic rise, fall, keep, is_edge;
    assign rise    = lvl[i] & ~prev_q[i];
    assign fall    = ~lvl[i] & prev_q[i];
    assign keep    = st_q[i] & ~clr[i];
    assign is_edge = (trig[i] == TRIG_RISE) || (trig[i] == TRIG_FALL) ||
                     (trig[i] == TRIG_BOTH);

    always_comb begin
      case (trig[i])
        TRIG_RISE: st_d[i] = rise | keep;
        TRIG_FALL: st_d[i] = fall | keep;
        TRIG_BOTH: st_d[i] = rise | fall | keep;
        TRIG_HIGH: st_d[i] = lvl[i];
        TRIG_LOW:  st_d[i] = ~lvl[i];
        default:   st_d[i] = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) st_q[i] <= 1'b0;
      else     st_q[i] <= st_d[i];
    end

    // R6: high-level status tracks the level seen one cycle earlier
    p_level_high_r6: assert property (@(posedge clk) disable iff (rst)
      (trig[i] == TRIG_HIGH) |=> (st_q[i] == $past(lvl[i])));

    // R8: unsupported codes never produce status
    p_invalid_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      (!is_edge && trig[i] != TRIG_HIGH && trig[i] != TRIG_LOW) |=> !st_q[i]);

    // R9: a set edge bit survives until cleared or re-coded
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      (is_edge && st_q[i] && !clr[i]) |=> (st_q[i] || !$past(is_edge) ||
        !((trig[i] == TRIG_RISE) || (trig[i] == TRIG_FALL) || (trig[i] == TRIG_BOTH))));
  end

  assign st = st_q;
endmodule

// File: rtl/gpir_route.sv
module gpir_route #(
  parameter int NPIN     = 16,
  parameter int NUM_OUTS = 4,
  parameter int OUT_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NPIN-1:0]            st,
  input  logic [NPIN-1:0]            ien,
  input  logic [NPIN-1:0][OUT_W-1:0] route,
  output logic [NUM_OUTS-1:0][NPIN-1:0] routed_st,
  output logic [NUM_OUTS-1:0]        irq
);
  logic [NUM_OUTS-1:0] irq_q;

  for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
    for (genvar b = 0; b < NPIN; b++) begin : g_bit
      assign routed_st[o][b] = st[b] & (route[b] == OUT_W'(o));
    end

    always_ff @(posedge clk) begin
      if (rst) irq_q[o] <= 1'b0;
      else     irq_q[o] <= |(routed_st[o] & ien);
    end

    // R10: an output rises only from a routed, enabled status bit
    p_irq_source_r10: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_q[o]) |-> $past(|(st & ien)));

    // R11: with every enable cleared, outputs go quiet
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
      (ien == '0) |=> !irq_q[o]);
  end

  assign irq = irq_q;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpir_pkg::*;
#(
  parameter int NUM_PORTS     = 2,
  parameter int PINS_PER_PORT = 8,
  parameter int NUM_OUTS      = 4,
  parameter int ADDR_W        = 6,
  parameter int DATA_W        = 32,
  localparam int NPIN      = NUM_PORTS * PINS_PER_PORT,
  localparam int OUT_W     = (NUM_OUTS > 1) ? $clog2(NUM_OUTS) : 1,
  localparam int STAT_BASE = NUM_PORTS * REG_STRIDE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NUM_OUTS-1:0] irq
);
  localparam int P = PINS_PER_PORT;

  logic [NPIN-1:0]              dir_q, out_q, ien_q, lvl, st, clr;
  logic [NPIN-1:0][TRIG_W-1:0]  trig_q;
  logic [NPIN-1:0][OUT_W-1:0]   route_q;
  logic [NUM_OUTS-1:0][NPIN-1:0] routed_st;
  logic [DATA_W-1:0]            rd_mux, rdata_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      trig_q  <= '0;
      route_q <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (hit(addr, p*REG_STRIDE + OFF_DIR)) dir_q[p*P +: P] <= wdata[P-1:0];
        if (hit(addr, p*REG_STRIDE + OFF_OUT)) out_q[p*P +: P] <= wdata[P-1:0];
        if (hit(addr, p*REG_STRIDE + OFF_IEN)) ien_q[p*P +: P] <= wdata[P-1:0];
        for (int i = 0; i < P; i++) begin
          if (hit(addr, p*REG_STRIDE + OFF_TRIG))
            trig_q[p*P+i] <= wdata[TRIG_W*i +: TRIG_W];
          if (hit(addr, p*REG_STRIDE + OFF_ROUTE))
            route_q[p*P+i] <= wdata[OUT_W*i +: OUT_W];
        end
      end
    end
  end

  // write-one-to-clear applies only to pins routed to the addressed output
  always_comb begin
    clr = '0;
    for (int o = 0; o < NUM_OUTS; o++)
      if (wr_en && hit(addr, STAT_BASE + o))
        for (int b = 0; b < NPIN; b++)
          if (wdata[b] && route_q[b] == OUT_W'(o)) clr[b] = 1'b1;
  end

  gpir_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl)
  );

  gpir_detect #(.NPIN(NPIN)) u_detect (
    .clk(clk), .rst(rst), .lvl(lvl), .trig(trig_q), .clr(clr), .st(st)
  );

  gpir_route #(.NPIN(NPIN), .NUM_OUTS(NUM_OUTS), .OUT_W(OUT_W)) u_route (
    .clk(clk), .rst(rst), .st(st), .ien(ien_q), .route(route_q),
    .routed_st(routed_st), .irq(irq)
  );

  // read multiplexer
  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hit(addr, p*REG_STRIDE + OFF_DIR)) rd_mux[P-1:0] = dir_q[p*P +: P];
      if (hit(addr, p*REG_STRIDE + OFF_OUT)) rd_mux[P-1:0] = out_q[p*P +: P];
      if (hit(addr, p*REG_STRIDE + OFF_IN))  rd_mux[P-1:0] = lvl[p*P +: P];
      if (hit(addr, p*REG_STRIDE + OFF_IEN)) rd_mux[P-1:0] = ien_q[p*P +: P];
      for (int i = 0; i < P; i++) begin
        if (hit(addr, p*REG_STRIDE + OFF_TRIG))
          rd_mux[TRIG_W*i +: TRIG_W] = trig_q[p*P+i];
        if (hit(addr, p*REG_STRIDE + OFF_ROUTE))
          rd_mux[OUT_W*i +: OUT_W] = route_q[p*P+i];
      end
    end
    for (int o = 0; o < NUM_OUTS; o++)
      if (hit(addr, STAT_BASE + o)) rd_mux[NPIN-1:0] = routed_st[o];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata   = rdata_q;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  // R2: the input register lags the pins by exactly the synchroniser depth
  p_sync_depth_r2: assert property (@(posedge clk) disable iff (rst || $past(rst) || $past(rst, 2))
    lvl == $past(pin_in, 2));

  // R1: pad controls move only on a bus write
  p_pads_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ($stable(pin_oe) && $stable(pin_out)));
endmodule

// File: tb/gpio_irq_router_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic [3:0]  irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  gpio_irq_router dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = 6'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    for (int o = 0; o < 4; o++) wr(16 + o, 32'hFFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 oe reset", 32'(pin_oe), 0);
    chk("R1 out reset", 32'(pin_out), 0);
    chk("R1 irq reset", 32'(irq), 0);
    for (int o = 0; o < 4; o++) begin
      rd(16 + o, d); chk("R1 status reset", d, 0);
    end
    rd(4, d); chk("R1 trig reset", d, 0);

    // R1 / R12 pad control and register addressing
    wr(0, 32'hA5); wr(8, 32'h3C); wr(1, 32'h0F); wr(9, 32'hF0);
    chk("R1 pin_oe", 32'(pin_oe), 32'h3CA5);
    chk("R1 pin_out", 32'(pin_out), 32'hF00F);
    rd(8, d);  chk("R12 dir port1", d, 32'h3C);
    rd(1, d);  chk("R12 out port0", d, 32'h0F);
    wr(12, 32'h8421_4321); rd(12, d); chk("R12 trig port1", d, 32'h8421_4321);
    wr(13, 32'hB1E4); rd(13, d); chk("R12 route port1", d, 32'hB1E4);
    wr(12, 0); wr(13, 0);

    // R2 synchronised input readback
    pin_in = 16'h5AC3;
    @(posedge clk); @(negedge clk);
    rd(2, d);  chk("R2 in port0", d, 32'hC3);
    rd(10, d); chk("R2 in port1", d, 32'h5A);
    pin_in = '0;
    settle(4);

    // Main sweep: every pin, every trigger code (R3..R9)
    for (int b = 0; b < 16; b++) begin
      for (int c = 0; c < 16; c++) begin
        int p, i, r;
        logic elo, ehi, eclr, efall;
        p = b / 8; i = b % 8; r = (b + c) % 4;
        wr(4,  (p == 0) ? (32'(c) << (4*i)) : 32'h0);
        wr(12, (p == 1) ? (32'(c) << (4*i)) : 32'h0);
        wr(5 + 8*p, 32'(r) << (2*i));
        wr(3 + 8*p, 32'(1) << i);
        wr(3 + 8*(1-p), 0);
        settle(4);
        clear_all();
        settle(2);
        elo   = (c == 8);
        ehi   = (c == 1) || (c == 3) || (c == 4);
        eclr  = (c == 4);
        efall = (c == 2) || (c == 3) || (c == 8);
        rd(16 + r, d);
        chk($sformatf("R7/R8 low settle pin%0d code%0d", b, c), d, 32'(elo) << b);
        pin_in = 16'(1) << b;
        settle(5);
        rd(16 + r, d);
        chk($sformatf("R3/R5/R6/R8 rise pin%0d code%0d", b, c), d, 32'(ehi) << b);
        chk($sformatf("R10 irq rise pin%0d code%0d", b, c), 32'(irq), 32'(ehi) << r);
        wr(16 + r, 0);
        settle(2);
        rd(16 + r, d);
        chk($sformatf("R9 write0 pin%0d code%0d", b, c), d, 32'(ehi) << b);
        wr(16 + r, 32'(1) << b);
        settle(2);
        rd(16 + r, d);
        chk($sformatf("R6/R9 w1c pin%0d code%0d", b, c), d, 32'(eclr) << b);
        pin_in = '0;
        settle(5);
        rd(16 + r, d);
        chk($sformatf("R4/R5/R7 fall pin%0d code%0d", b, c), d, 32'(efall) << b);
      end
    end

    // Routing sweep with level-high pins (R10, R11)
    wr(4, 32'h4444_4444); wr(12, 32'h4444_4444);
    wr(5, 32'hE4E4); wr(13, 32'hE4E4);
    wr(3, 32'hFF); wr(11, 32'hFF);
    for (int k = 0; k < 6; k++) begin
      logic [15:0] pat;
      logic [3:0] eirq;
      pat = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0001 : (k == 2) ? 16'h8421 :
            (k == 3) ? 16'h1248 : (k == 4) ? 16'hF0A0 : 16'h0000;
      pin_in = pat;
      settle(5);
      eirq = '0;
      for (int o = 0; o < 4; o++) begin
        logic [15:0] m;
        m = 16'h1111 << o;
        eirq[o] = |(pat & m);
        rd(16 + o, d);
        chk($sformatf("R10 status out%0d pat%h", o, pat), d, 32'(pat & m));
      end
      chk($sformatf("R10 irq pat%h", pat), 32'(irq), 32'(eirq));
      wr(3, 0);
      settle(2);
      eirq = '0;
      for (int o = 0; o < 4; o++) eirq[o] = |(pat & (16'h1111 << o) & 16'hFF00);
      chk($sformatf("R11 masked irq pat%h", pat), 32'(irq), 32'(eirq));
      rd(16 + (k % 4), d);
      chk($sformatf("R11 status kept pat%h", pat), d, 32'(pat & (16'h1111 << (k % 4))));
      wr(3, 32'hFF);
    end
    pin_in = '0;
    settle(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule